// File: doc/BRIEF.md
# Queue Pointer Interrupt Monitor

This block keeps the head and tail pointers of four in-memory message queues: one for messages between processors, one for device messages, one for resumable errors and one for non-resumable errors. Software reaches all eight pointers through one register port. A 3-bit index selects the pointer, a write-enable stores a 64-bit value, and the selected pointer comes back on a registered read bus.

Each write to a head or tail pointer makes the block decide again whether that queue holds unread entries. A queue counts as non-empty when its head and tail differ. The processor-message, device-message and resumable-error queues each drive a level interrupt that reflects this test. The non-resumable error queue stores its pointers but never raises an interrupt. The queue storage, pointer wrap arithmetic and trap delivery belong to other blocks.

Top module: `queue_irq_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all eight pointers, `reg_rdata` and all three interrupt outputs become zero.
- R2: The index encoding is as follows. `reg_idx[2:1]` selects the queue: 0 is processor messages, 1 is device messages, 2 is resumable errors, 3 is non-resumable errors. `reg_idx[0]` selects the pointer: 0 is head, 1 is tail. When `reg_we` is high at an edge, `reg_wdata` is stored into the selected pointer.
- R3: After every edge, `reg_rdata` holds the pointer selected by `reg_idx` at that edge, as it stood before any write at that same edge.
- R4: One cycle after a write to the processor-message queue, `irq_xcpu` is high if that queue's head and tail differ and low if they are equal.
- R5: One cycle after a write to the device-message queue, `irq_dev` is high if that queue's head and tail differ and low if they are equal.
- R6: One cycle after a write to the resumable-error queue, `irq_rerr` is high if that queue's head and tail differ and low if they are equal.
- R7: Writes to the non-resumable error queue are stored and can be read back, but they never assert any interrupt output, even when its head and tail differ.
- R8: A write to the head pointer and a write to the tail pointer both trigger the re-evaluation. Either pointer can raise or clear the interrupt.
- R9: A cycle with `reg_we` low changes no pointer and no interrupt output, whatever the value of `reg_idx`.
- R10: A write to one queue leaves the interrupt outputs of the other queues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write enable for the selected pointer |
| reg_idx | input | 3 | Pointer select: queue in [2:1], head/tail in [0] |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq_xcpu | output | 1 | Processor-message queue not empty |
| irq_dev | output | 1 | Device-message queue not empty |
| irq_rerr | output | 1 | Resumable-error queue not empty |

## Verification
The directed sequences set and clear each interrupt in three ways: by writing the head, by writing the tail, and by writing a value equal to the other pointer. This shows whether both pointers feed the comparison. Writes that make the non-resumable queue's pointers differ show whether that queue is left out of the interrupts. A following run of random writes mixed with idle reads covers further cases. In that run, pointers differ only in high bits, or writes go to one queue while another's interrupt is high. These patterns expose a narrow compare, crosstalk between queues, and a read bus that returns the value after the write instead of before it.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  // Queue numbering used in reg_idx[2:1]
  typedef enum logic [1:0] {
    Q_XCPU  = 2'd0,
    Q_DEV   = 2'd1,
    Q_RERR  = 2'd2,
    Q_NRERR = 2'd3
  } queue_e;

  // Pointer select within a queue, reg_idx[0]
  localparam logic SEL_HEAD = 1'b0;
  localparam logic SEL_TAIL = 1'b1;
endpackage

// File: rtl/qmon_ptr_bank.sv
module qmon_ptr_bank #(
  parameter int PTR_W   = 64,
  parameter int NUM_PTR = 8,
  localparam int IDX_W  = $clog2(NUM_PTR)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [IDX_W-1:0]               idx,
  input  logic [PTR_W-1:0]               wdata,
  output logic [NUM_PTR-1:0][PTR_W-1:0]  ptrs,
  output logic [PTR_W-1:0]               rdata
);

  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;

  // One register per pointer; each decodes its own write strobe
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[i] <= '0;
      end else if (we && (idx == IDX_W'(i))) begin
        ptr_q[i] <= wdata;
      end
    end
  end

  // Registered read; returns the value held before a same-edge write
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= ptr_q[idx];
    end
  end

  assign ptrs = ptr_q;

  // R3: read bus carries the pre-write pointer selected one edge earlier
  p_read_old_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rdata == $past(ptr_q[idx])));

endmodule

// File: rtl/qmon_irq_eval.sv
module qmon_irq_eval #(
  parameter int PTR_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,   // write addressed to this queue
  input  logic             wr_tail,  // 1: tail written, 0: head written
  input  logic [PTR_W-1:0] wdata,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] tail,
  output logic             irq
);
  import qmon_pkg::*;

  logic [PTR_W-1:0] head_nx;
  logic [PTR_W-1:0] tail_nx;
  logic             irq_q;

  // Pointer pair as it will stand after this edge's write
  always_comb begin
    head_nx = head;
    tail_nx = tail;
    if (wr_tail == SEL_TAIL) begin
      tail_nx = wdata;
    end else begin
      head_nx = wdata;
    end
  end

  // Re-evaluated only when this queue is written
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (wr_hit) begin
      irq_q <= (head_nx != tail_nx);
    end
  end

  assign irq = irq_q;

  // R8: after a write, the line matches the stored pair from the bank
  p_eval_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (irq == (head != tail)));

  // R10: without a write to this queue the line holds
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(irq));

  // R1: reset leaves the line low
  p_reset_low_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq);

endmodule

// File: rtl/queue_irq_monitor.sv
module queue_irq_monitor #(
  parameter int PTR_W   = 64,
  parameter int NUM_Q   = 4,
  parameter int NUM_IRQ = 3,
  localparam int NUM_PTR = 2 * NUM_Q,
  localparam int IDX_W   = $clog2(NUM_PTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             irq_xcpu,
  output logic             irq_dev,
  output logic             irq_rerr
);
  import qmon_pkg::*;

  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
  logic [NUM_IRQ-1:0]            q_irq;
  logic [PTR_W-1:0]              rdata_w;

  qmon_ptr_bank #(
    .PTR_W   (PTR_W),
    .NUM_PTR (NUM_PTR)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .idx   (IDX_W'(reg_idx)),
    .wdata (PTR_W'(reg_wdata)),
    .ptrs  (ptrs),
    .rdata (rdata_w)
  );

  // Only the first NUM_IRQ queues carry an interrupt; the rest are storage only
  for (genvar q = 0; q < NUM_IRQ; q++) begin : g_irq
    qmon_irq_eval #(
      .PTR_W (PTR_W)
    ) u_eval (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (reg_we && (reg_idx[2:1] == 2'(q))),
      .wr_tail (reg_idx[0]),
      .wdata   (PTR_W'(reg_wdata)),
      .head    (ptrs[2*q]),
      .tail    (ptrs[2*q+1]),
      .irq     (q_irq[q])
    );
  end

  assign reg_rdata = 64'(rdata_w);
  assign irq_xcpu  = q_irq[Q_XCPU];
  assign irq_dev   = q_irq[Q_DEV];
  assign irq_rerr  = q_irq[Q_RERR];

  // R7: writes to the non-resumable queue disturb no interrupt
  p_nrerr_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx[2:1] == Q_NRERR) |=> $stable(q_irq));

  // R9: idle cycles leave every pointer alone
  p_idle_no_change_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(ptrs));

  // R4: processor-message line tracks its pointer pair after a write to it
  p_xcpu_level_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx[2:1] == Q_XCPU) |=> (irq_xcpu == (ptrs[0] != ptrs[1])));

endmodule

// File: tb/sim_queue_irq_monitor.sv
module sim_queue_irq_monitor;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [2:0]  reg_idx;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        irq_xcpu, irq_dev, irq_rerr;

  always #2.5 clk = ~clk;  // 200 MHz

  queue_irq_monitor u0 (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_xcpu  (irq_xcpu),
    .irq_dev   (irq_dev),
    .irq_rerr  (irq_rerr)
  );

  // Behavioural model
  logic [63:0] m_ptr [8];
  logic [63:0] m_rdata;
  logic [2:0]  m_irq;
  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 rdata", reg_rdata, m_rdata);
    chk("R4 irq_xcpu", 64'(irq_xcpu), 64'(m_irq[0]));
    chk("R5 irq_dev",  64'(irq_dev),  64'(m_irq[1]));
    chk("R6 irq_rerr", 64'(irq_rerr), 64'(m_irq[2]));
  endtask

  task automatic step(input bit we, input int idx, input logic [63:0] d);
    reg_we    = we;
    reg_idx   = 3'(idx);
    reg_wdata = d;
    @(posedge clk);
    m_rdata = m_ptr[idx];
    if (we) begin
      m_ptr[idx] = d;
      if ((idx >> 1) < 3)
        m_irq[idx >> 1] = (m_ptr[(idx >> 1) * 2] != m_ptr[(idx >> 1) * 2 + 1]);
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input int idx);
    step(1'b0, idx, 64'hDEAD_BEEF_0000_0000 | 64'(idx));
  endtask

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 64'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; reg_we = 1'b0;
    for (int i = 0; i < 8; i++) m_ptr[i] = '0;
    m_rdata = '0; m_irq = '0;
    // R1: reset state
    chk("R1 rdata", reg_rdata, 64'h0);
    chk("R1 irqs", 64'({irq_rerr, irq_dev, irq_xcpu}), 64'h0);
    for (int i = 0; i < 8; i++) rd(i);

    // R4 / R8: raise by head, clear by tail equal to head
    step(1'b1, 0, 64'h5);
    chk("R4 set by head", 64'(irq_xcpu), 64'h1);
    step(1'b1, 1, 64'h5);
    chk("R8 clear by tail", 64'(irq_xcpu), 64'h0);
    // R5 / R8: raise by tail, clear by head
    step(1'b1, 3, 64'h9);
    chk("R5 set by tail", 64'(irq_dev), 64'h1);
    chk("R10 xcpu untouched", 64'(irq_xcpu), 64'h0);
    step(1'b1, 2, 64'h9);
    chk("R8 clear by head", 64'(irq_dev), 64'h0);
    // R6: difference only in the top bit
    step(1'b1, 5, 64'h8000_0000_0000_0000);
    chk("R6 top bit differs", 64'(irq_rerr), 64'h1);
    // R10: write other queue while rerr is high
    step(1'b1, 0, 64'h77);
    chk("R10 rerr held", 64'(irq_rerr), 64'h1);
    // R7: non-resumable queue never interrupts
    step(1'b1, 6, 64'h7);
    step(1'b1, 7, 64'h3);
    chk("R7 no irq change", 64'({irq_rerr, irq_dev, irq_xcpu}), 64'b101);
    rd(6);
    rd(7);
    chk("R2 nrerr tail stored", reg_rdata, 64'h3);
    // R9: idle cycles with every index change nothing
    for (int i = 0; i < 8; i++) rd(i);
    chk("R9 irqs after reads", 64'({irq_rerr, irq_dev, irq_xcpu}), 64'b101);
    // R3: read and write same pointer at one edge returns old value
    step(1'b1, 4, 64'hABCD);
    chk("R3 old value on same-edge write", reg_rdata, 64'h0);
    rd(4);
    chk("R2 head stored", reg_rdata, 64'hABCD);

    // Random mix, compared every clock
    for (int n = 0; n < 2000; n++) begin
      int idx;
      logic [63:0] d;
      idx = int'($urandom_range(0, 7));
      d = ($urandom_range(0, 3) == 0) ? m_ptr[idx ^ 1]
                                      : {32'($urandom_range(0, 3)), 32'($urandom_range(0, 3))};
      step($urandom_range(0, 2) != 0, idx, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule